// File: doc/BRIEF.md
# Data Cache March Test Sequencer

This block is a hardware sequencer for testing a data cache. It walks a fixed set of addresses twice. On each visit it issues write and read requests over a simple request/acknowledge memory port. For every access it checks two things: the read data, and the hit or miss flag that a bus monitor reports along with the acknowledge. A wrong flag counts as a failure just as wrong data does. This checks the cache controller's allocation and tag comparison, and not only the data storage.

The first pass targets one tag region and fills every cache word. Each word is written with a pattern, which must miss, and then read back, which must hit and return the pattern. The second pass targets an alias region one cache size higher, so every index now sees a new tag. Each word is read, which must miss, then written with the complement of the pattern, which must hit, then read again, which must hit and return the complement.

A start pulse launches a run. The sequencer stops at the first failing access. When it ends, it raises done, together with fail, the failing address and the pass in which the failure occurred.

Top module: `cmt_seq`

## Requirements
- R1: While rst_ni is low, and after it rises, req_o, done_o and fail_o are low until a start is accepted.
- R2: A start_i pulse while idle is accepted. In the next cycle req_o is high, and done_o and fail_o are low.
- R3: Once raised, req_o, addr_o, we_o and wdata_o hold their values until the cycle in which ack_i is high. rdata_i and hit_i are sampled only in that cycle.
- R4: With N = NUM_BLK*WPB accesses per pass, the address for pass p (0 or 1) and step k (0..N-1) is BASE + p*CACHE_BYTES + (k mod NUM_BLK)*BLK_BYTES + (k div NUM_BLK)*WORD_BYTES. With the defaults these are 128, 16, 4 and BASE=0.
- R5: In pass 0, each step first writes PATTERN (we_o=1) and expects hit_i=0. It then reads (we_o=0) and expects hit_i=1 and rdata_i equal to PATTERN.
- R6: In pass 1, each step first reads and expects hit_i=0; its data is not checked. It then writes ~PATTERN and expects hit_i=1. It then reads again and expects hit_i=1 and rdata_i XOR ~PATTERN equal to zero.
- R7: On the first acknowledged access whose hit flag or checked data disagrees, the sequencer issues no further request. It sets done_o=1 and fail_o=1, fail_addr_o to that access's address, and fail_phase_o to the pass (0 or 1).
- R8: If all 5*N accesses agree, done_o rises after the last acknowledge with fail_o=0.
- R9: A start_i pulse while a run is in progress has no effect on the request sequence or the result.
- R10: done_o and the result outputs keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| req_o | output | 1 | Access request |
| we_o | output | 1 | 1 = write, 0 = read |
| addr_o | output | AW | Byte address of the access |
| wdata_o | output | DW | Write data |
| ack_i | input | 1 | Access complete, one cycle |
| rdata_i | input | DW | Read data, valid with ack_i |
| hit_i | input | 1 | Monitor hit flag, valid with ack_i |
| done_o | output | 1 | Run finished |
| fail_o | output | 1 | Run ended on a mismatch |
| fail_addr_o | output | AW | Address of the failing access |
| fail_phase_o | output | 1 | Pass of the failing access |

## Verification
The bench injects a faulty response at chosen points, one at a time:
- Corrupted data on a pass-0 readback. A sequencer that skipped this check would run to a clean finish.
- A hit reported on the very last pass-0 write. This catches a design that reverses the expected flag, or that latches the address of the next step.
- A miss reported on a pass-1 write.
- A corrupted value on the final pass-1 readback. This catches a design that compares against the plain pattern instead of its complement.

A second start pulse is sent in the middle of a run. A design that restarted on it would break the expected request order held in the scoreboard. After each run the bench checks that done stays high and that no stray request appears.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  typedef enum logic [2:0] {
    OP_P0_WR  = 3'd0,
    OP_P0_RD  = 3'd1,
    OP_P1_RD0 = 3'd2,
    OP_P1_WR  = 3'd3,
    OP_P1_RD1 = 3'd4
  } op_e;
endpackage

// File: rtl/cmt_addr_gen.sv
module cmt_addr_gen #(
  parameter int unsigned    AW          = 32,
  parameter int unsigned    NUM_BLK     = 8,
  parameter int unsigned    WPB         = 4,
  parameter int unsigned    WORD_BYTES  = 4,
  parameter logic [AW-1:0]  BASE        = '0,
  localparam int unsigned   NUM_ACC     = NUM_BLK * WPB,
  localparam int unsigned   IW          = $clog2(NUM_ACC)
) (
  input  logic          phase_i,
  input  logic [IW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned BLK_BYTES   = WORD_BYTES * WPB;
  localparam int unsigned CACHE_BYTES = BLK_BYTES * NUM_BLK;
  localparam int unsigned BLK_W       = $clog2(NUM_BLK);
  localparam int unsigned OFF_BLK     = $clog2(BLK_BYTES);
  localparam int unsigned OFF_WRD     = $clog2(WORD_BYTES);

  logic [BLK_W-1:0]    blk;
  logic [IW-BLK_W-1:0] wrd;

  // block index steps fastest so consecutive accesses land in different sets
  assign blk = idx_i[BLK_W-1:0];
  assign wrd = idx_i[IW-1:BLK_W];

  always_comb begin
    addr_o = BASE
           + (phase_i ? AW'(CACHE_BYTES) : '0)
           + (AW'(blk) << OFF_BLK)
           + (AW'(wrd) << OFF_WRD);
  end
endmodule

// File: rtl/cmt_resp_chk.sv
module cmt_resp_chk
  import cmt_pkg::*;
#(
  parameter int unsigned   DW      = 32,
  parameter logic [DW-1:0] PATTERN = '0
) (
  input  op_e           op_i,
  input  logic          hit_i,
  input  logic [DW-1:0] rdata_i,
  output logic          err_o
);
  logic exp_hit;
  logic data_bad;

  always_comb begin
    exp_hit  = (op_i == OP_P0_RD) || (op_i == OP_P1_WR) || (op_i == OP_P1_RD1);
    data_bad = 1'b0;
    unique case (op_i)
      OP_P0_RD:  data_bad = (rdata_i != PATTERN);
      OP_P1_RD1: data_bad = |(rdata_i ^ ~PATTERN);
      default:   data_bad = 1'b0;
    endcase
    err_o = (hit_i != exp_hit) || data_bad;
  end
endmodule

// File: rtl/cmt_seq.sv
module cmt_seq
  import cmt_pkg::*;
#(
  parameter int unsigned   AW      = 32,
  parameter int unsigned   DW      = 32,
  parameter int unsigned   NUM_BLK = 8,
  parameter int unsigned   WPB     = 4,
  parameter logic [DW-1:0] PATTERN = 32'hA5C3_5A3C,
  parameter logic [AW-1:0] BASE    = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          hit_i,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic          fail_phase_o
);
  localparam int unsigned WORD_BYTES = DW / 8;
  localparam int unsigned NUM_ACC    = NUM_BLK * WPB;
  localparam int unsigned IW         = $clog2(NUM_ACC);

  logic          busy_q;
  op_e           op_q;
  logic [IW-1:0] idx_q;
  logic          phase;
  logic          last_idx;
  logic          err;

  assign phase    = (op_q == OP_P1_RD0) || (op_q == OP_P1_WR) || (op_q == OP_P1_RD1);
  assign last_idx = (idx_q == IW'(NUM_ACC - 1));
  assign req_o    = busy_q;
  assign we_o     = (op_q == OP_P0_WR) || (op_q == OP_P1_WR);
  assign wdata_o  = (op_q == OP_P1_WR) ? ~PATTERN : PATTERN;

  cmt_addr_gen #(
    .AW(AW), .NUM_BLK(NUM_BLK), .WPB(WPB), .WORD_BYTES(WORD_BYTES), .BASE(BASE)
  ) i_addr_gen (
    .phase_i(phase),
    .idx_i  (idx_q),
    .addr_o (addr_o)
  );

  cmt_resp_chk #(
    .DW(DW), .PATTERN(PATTERN)
  ) i_resp_chk (
    .op_i   (op_q),
    .hit_i  (hit_i),
    .rdata_i(rdata_i),
    .err_o  (err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      op_q         <= OP_P0_WR;
      idx_q        <= '0;
      done_o       <= 1'b0;
      fail_o       <= 1'b0;
      fail_addr_o  <= '0;
      fail_phase_o <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q       <= 1'b1;
        op_q         <= OP_P0_WR;
        idx_q        <= '0;
        done_o       <= 1'b0;
        fail_o       <= 1'b0;
        fail_addr_o  <= '0;
        fail_phase_o <= 1'b0;
      end
    end else if (ack_i) begin
      if (err) begin
        busy_q       <= 1'b0;
        done_o       <= 1'b1;
        fail_o       <= 1'b1;
        fail_addr_o  <= addr_o;
        fail_phase_o <= phase;
      end else begin
        unique case (op_q)
          OP_P0_WR:  op_q <= OP_P0_RD;
          OP_P0_RD: begin
            op_q  <= last_idx ? OP_P1_RD0 : OP_P0_WR;
            idx_q <= last_idx ? '0 : idx_q + 1'b1;
          end
          OP_P1_RD0: op_q <= OP_P1_WR;
          OP_P1_WR:  op_q <= OP_P1_RD1;
          OP_P1_RD1: begin
            if (last_idx) begin
              busy_q <= 1'b0;
              done_o <= 1'b1;
            end else begin
              op_q  <= OP_P1_RD0;
              idx_q <= idx_q + 1'b1;
            end
          end
          default: op_q <= OP_P0_WR;
        endcase
      end
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !req_o && !done_o && !fail_o);

  a_r2_start_launches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o && start_i |=> req_o && !done_o && !fail_o);

  a_r3_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o));

  a_r4_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> addr_o[$clog2(WORD_BYTES)-1:0] == '0);

  a_r7_fail_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o && !req_o);

  a_r9_start_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && start_i && !ack_i |=> req_o && $stable(addr_o));

  a_r10_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(fail_o) && $stable(fail_addr_o));
endmodule

// File: tb/test_cmt_seq.sv
`timescale 1ns/1ps
module test_cmt_seq;
  localparam int unsigned N         = 32;   // NUM_BLK*WPB
  localparam int unsigned CBYTES    = 128;
  localparam logic [31:0] PAT       = 32'hA5C3_5A3C;

  typedef struct {
    logic [31:0] a;
    logic        w;
    logic [31:0] d;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req, we, ack = 1'b0, hit = 1'b0, done, fail, fail_ph;
  logic [31:0] addr, wdata, rdata = '0, fail_addr;

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  item_t       q[$];
  logic        c_valid [N];
  logic [31:0] c_tag   [N];
  logic [31:0] c_data  [N];
  logic [31:0] mem [logic [31:0]];

  int          fk = 0;         // 0 none, 1 flip data, 2 flip hit, 3 flip data on hit read
  logic [31:0] fa = '0;
  logic        fw = 1'b0;

  always #2.5 clk = ~clk;

  cmt_seq i_cmt_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .req_o(req), .we_o(we), .addr_o(addr), .wdata_o(wdata),
    .ack_i(ack), .rdata_i(rdata), .hit_i(hit),
    .done_o(done), .fail_o(fail), .fail_addr_o(fail_addr), .fail_phase_o(fail_ph)
  );

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(int p, int k);
    return p * CBYTES + (k % 8) * 16 + (k / 8) * 4;
  endfunction

  // driver: expected request stream, cut after the injected fault (R4, R5, R6, R7)
  task automatic push_seq();
    item_t it;
    q.delete();
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < N; k++) begin
        for (int s = 0; s < (p == 0 ? 2 : 3); s++) begin
          it.a = exp_addr(p, k);
          it.w = (p == 0) ? (s == 0) : (s == 1);
          it.d = (p == 1 && s == 1) ? ~PAT : PAT;
          q.push_back(it);
          if (fk != 0 && it.a == fa && it.w == fw &&
              !(fk == 3 && !(p == 1 && s == 2))) return;
        end
      end
    end
  endtask

  // monitor + behavioural direct-mapped cache, word granular, write-allocate
  initial begin
    item_t       e;
    int          ix;
    logic [31:0] tg;
    logic        h;
    logic [31:0] rd;
    forever begin
      @(negedge clk);
      if (ack) begin
        ack = 1'b0;
      end else if (req) begin
        if (q.size() == 0) begin
          chk(1'b0, "R7", "unexpected request", addr, '0);
        end else begin
          e = q.pop_front();
          chk(addr == e.a, "R4", "address", addr, e.a);
          chk(we == e.w, "R5/R6", "direction", {31'd0, we}, {31'd0, e.w});
          if (e.w) chk(wdata == e.d, "R6", "write data", wdata, e.d);
        end
        ix = (addr % CBYTES) / 4;
        tg = addr / CBYTES;
        h  = c_valid[ix] && c_tag[ix] == tg;
        if (we) begin
          c_valid[ix] = 1'b1; c_tag[ix] = tg; c_data[ix] = wdata; mem[addr] = wdata;
        end else if (!h) begin
          c_valid[ix] = 1'b1; c_tag[ix] = tg;
          c_data[ix] = mem.exists(addr) ? mem[addr] : '0;
        end
        rd = c_data[ix];
        if (addr == fa && we == fw) begin
          if (fk == 1) rd = rd ^ 32'h1;
          if (fk == 2) h = ~h;
          if (fk == 3 && h) rd = rd ^ 32'h8000_0000;
        end
        rdata = rd;
        hit   = h;
        ack   = 1'b1;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run(int kind, logic [31:0] faddr, logic fwe, bit exp_fail,
                     logic exp_ph, bit busy_poke, string rq);
    int t;
    fk = kind; fa = faddr; fw = fwe;
    for (int i = 0; i < N; i++) c_valid[i] = 1'b0;
    mem.delete();
    push_seq();
    pulse_start();
    chk(req && !done && !fail, "R2", "launch", {30'd0, done, req}, 32'd1);
    if (busy_poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;   // R9
      chk(!done, "R9", "start while busy", {31'd0, done}, '0);
    end
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done, rq, "done reached", {31'd0, done}, 32'd1);
    chk(fail == exp_fail, rq, "fail flag", {31'd0, fail}, {31'd0, exp_fail});
    if (exp_fail) begin
      chk(fail_addr == faddr, "R7", "fail address", fail_addr, faddr);
      chk(fail_ph == exp_ph, "R7", "fail phase", {31'd0, fail_ph}, {31'd0, exp_ph});
    end
    chk(q.size() == 0, rq, "requests outstanding", q.size(), 0);
    repeat (8) @(negedge clk);
    chk(done && !req, "R10", "done held, no request", {30'd0, req, done}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!req && !done && !fail, "R1", "in reset", {29'd0, fail, done, req}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!req && !done && !fail, "R1", "after reset", {29'd0, fail, done, req}, '0);

    run(0, '0, 1'b0, 1'b0, 1'b0, 1'b1, "R8");                       // clean, with R9 poke
    run(1, exp_addr(0, 21), 1'b0, 1'b1, 1'b0, 1'b0, "R5");          // pass-0 readback data
    run(2, exp_addr(0, 31), 1'b1, 1'b1, 1'b0, 1'b0, "R5");          // last pass-0 write hits
    run(2, exp_addr(1, 10), 1'b1, 1'b1, 1'b1, 1'b0, "R6");          // pass-1 write misses
    run(3, exp_addr(1, 5),  1'b0, 1'b1, 1'b1, 1'b0, "R6");          // pass-1 final read data
    run(0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");                       // clean again after failure

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule